// File: doc/BRIEF.md
# Store and Recall Protection Controller

This block owns a small working RAM image of 16 words of 16 bits and a shadow nonvolatile copy of the same size, held here as a plain register file. It moves the whole array in either direction: a store copies the RAM image into the shadow array, and a recall copies the shadow array back into the RAM image. Requests come from a decoded command interface and from two active-low hardware pins. Store and recall durations are modelled by cycle counters whose lengths are parameters.

The block keeps two protection latches: a write-enable latch and a recall-done latch. A store runs only when both latches are set and the supply-low input is quiet. A finished store drops the write-enable latch. After reset the block waits out a power-up delay, then recalls the shadow array on its own. While any transfer or the power-up wait is in progress, the busy output is high and every other request is dropped. Read ports show both arrays at all times.

Top module: `nvsr_ctrl`

## Requirements
- R1: During and after reset, busy is 1 and both latches are 0. Busy stays high for PUP_CYCLES + RECALL_CYCLES cycles, plus up to two cycles for reset release. After that the RAM image equals the shadow array. The shadow array comes out of reset with word i equal to bits [WIDTH-1:0] of (i*0x9E37) xor 0x5AC3. This power-on recall leaves the recall-done latch at 0.
- R2: With cmd_valid high and busy low, cmd_op 2'b00 sets the write-enable latch and 2'b01 clears it. While supply_low is high, the latch is cleared and cannot be set.
- R3: A store begins only when a store request is present, the write-enable latch is 1, the recall-done latch is 1 and supply_low is 0. A store request is cmd_op 2'b10 or a falling edge on store_pin_n. A refused store request changes nothing.
- R4: A store holds busy high for exactly STORE_CYCLES cycles. When busy falls, the shadow array equals the RAM image and the write-enable latch is 0.
- R5: A recall request is cmd_op 2'b11 or a falling edge on recall_pin_n. A recall holds busy high for exactly RECALL_CYCLES cycles. At its end the RAM image equals the shadow array and the recall-done latch is 1.
- R6: If both pins fall in the same cycle, a store is taken when R3 allows it. Otherwise the recall is taken. Only one operation runs.
- R7: While busy is high, commands, pin edges and RAM writes have no effect.
- R8: If supply_low rises during a store, busy falls in the next cycle. The shadow array stays unchanged and the write-enable latch is cleared.
- R9: A pin held low for any length of time starts exactly one operation.
- R10: A RAM write (wr_en, wr_addr, wr_data) is taken only when busy is low and both latches are 1. Both read ports always show the current word at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Command code (00 set enable, 01 clear enable, 10 store, 11 recall) |
| store_pin_n | input | 1 | Asynchronous active-low store request pin |
| recall_pin_n | input | 1 | Asynchronous active-low recall request pin |
| supply_low | input | 1 | Supply below safe store level |
| wr_en | input | 1 | RAM image write strobe |
| wr_addr | input | AW | RAM image write address |
| wr_data | input | WIDTH | RAM image write data |
| rd_addr | input | AW | Read address for both arrays |
| ram_rdata | output | WIDTH | RAM image word at rd_addr |
| nv_rdata | output | WIDTH | Shadow word at rd_addr |
| busy | output | 1 | Power-up wait, store or recall in progress |
| wen_latch | output | 1 | Write-enable latch state |
| recall_latch | output | 1 | Recall-done latch state |

## Verification
Store requests are tried with every mix of the two latches and supply_low. The outcome shows that each precondition acts on its own. Requests sent while busy, simultaneous pin edges and pins held low for hundreds of cycles separate the ignore rule, the priority rule and the single-trigger rule. A store aborted partway through shows that the supply lockout cuts a running copy, not just a start. A seeded random mix of commands, pin pulses, writes and supply dips is then compared against a reference model of both arrays and both latches.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

  typedef enum logic [1:0] {
    OP_WEN_SET = 2'b00,
    OP_WEN_CLR = 2'b01,
    OP_STORE   = 2'b10,
    OP_RECALL  = 2'b11
  } nv_op_e;

  typedef enum logic [1:0] {
    ST_PWRUP  = 2'b00,
    ST_IDLE   = 2'b01,
    ST_STORE  = 2'b10,
    ST_RECALL = 2'b11
  } nv_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvsr_pin_edge.sv
module nvsr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb sync_d = {sync_q[STAGES-2:0], pin_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/nvsr_seq.sv
module nvsr_seq
  import nvsr_pkg::*;
#(
  parameter int PUP_CYCLES    = 20,
  parameter int STORE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       store_fall,
  input  logic       recall_fall,
  input  logic       supply_low,
  input  logic       wel,
  input  logic       prl,
  output logic       busy,
  output logic       store_start,
  output logic       store_done,
  output logic       recall_done,
  output logic       recall_auto
);
  localparam int MAXC = max3(PUP_CYCLES, STORE_CYCLES, RECALL_CYCLES);
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] PUP_LAST = CW'(PUP_CYCLES - 1);
  localparam logic [CW-1:0] STO_LAST = CW'(STORE_CYCLES - 1);
  localparam logic [CW-1:0] RCL_LAST = CW'(RECALL_CYCLES - 1);

  nv_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          auto_q, auto_d;
  logic          store_req, recall_req, store_ok;

  always_comb begin
    store_req  = (cmd_valid && cmd_op == OP_STORE) || store_fall;
    recall_req = (cmd_valid && cmd_op == OP_RECALL) || recall_fall;
    store_ok   = store_req && wel && prl && !supply_low;
  end

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    auto_d      = auto_q;
    store_start = 1'b0;
    store_done  = 1'b0;
    recall_done = 1'b0;
    case (state_q)
      ST_PWRUP: begin
        if (cnt_q == PUP_LAST) begin
          state_d = ST_RECALL;
          cnt_d   = '0;
          auto_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_IDLE: begin
        if (store_ok) begin
          state_d     = ST_STORE;
          cnt_d       = '0;
          store_start = 1'b1;
        end else if (recall_req) begin
          state_d = ST_RECALL;
          cnt_d   = '0;
          auto_d  = 1'b0;
        end
      end
      ST_STORE: begin
        if (supply_low) begin
          state_d = ST_IDLE;
        end else if (cnt_q == STO_LAST) begin
          store_done = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_RECALL: begin
        if (cnt_q == RCL_LAST) begin
          recall_done = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
      cnt_q   <= '0;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      auto_q  <= auto_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign recall_auto = auto_q;
endmodule

// File: rtl/nvsr_latches.sv
module nvsr_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic set_we,
  input  logic clr_we,
  input  logic set_rl,
  output logic wel,
  output logic prl
);
  logic wel_q, wel_d, wel_en;
  logic prl_q;

  always_comb begin
    wel_en = set_we | clr_we;
    wel_d  = ~clr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      prl_q <= 1'b0;
    end else begin
      if (wel_en) wel_q <= wel_d;
      if (set_rl) prl_q <= 1'b1;
    end
  end

  assign wel = wel_q;
  assign prl = prl_q;
endmodule

// File: rtl/nvsr_arrays.sv
module nvsr_arrays #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16,
  localparam int AW   = (WORDS < 2) ? 1 : $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             copy_to_nv,
  input  logic             copy_to_ram,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] ram_rdata,
  output logic [WIDTH-1:0] nv_rdata
);
  logic [WIDTH-1:0] ram_q [WORDS];
  logic [WIDTH-1:0] nv_q  [WORDS];

  function automatic logic [WIDTH-1:0] seed_word(int unsigned i);
    logic [31:0] v;
    v = (i * 32'h9E37) ^ 32'h5AC3;
    return v[WIDTH-1:0];
  endfunction

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic             ram_en;
    logic [WIDTH-1:0] ram_d;

    always_comb begin
      ram_en = copy_to_ram | (wr_ok & (wr_addr == AW'(w)));
      ram_d  = copy_to_ram ? nv_q[w] : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ram_q[w] <= '0;
        nv_q[w]  <= seed_word(w);
      end else begin
        if (ram_en)     ram_q[w] <= ram_d;
        if (copy_to_nv) nv_q[w]  <= ram_q[w];
      end
    end
  end

  assign ram_rdata = ram_q[rd_addr];
  assign nv_rdata  = nv_q[rd_addr];
endmodule

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
  import nvsr_pkg::*;
#(
  parameter int WORDS         = 16,
  parameter int WIDTH         = 16,
  parameter int PUP_CYCLES    = 20,
  parameter int STORE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int AW           = (WORDS < 2) ? 1 : $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             store_pin_n,
  input  logic             recall_pin_n,
  input  logic             supply_low,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] ram_rdata,
  output logic [WIDTH-1:0] nv_rdata,
  output logic             busy,
  output logic             wen_latch,
  output logic             recall_latch
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int = rst_q[1];

  // pin synchronizers, index 0 store, 1 recall
  logic [1:0] pins_n;
  logic [1:0] pin_fall;
  assign pins_n = {recall_pin_n, store_pin_n};

  for (genvar p = 0; p < 2; p++) begin : g_pin
    nvsr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_int),
      .pin_n (pins_n[p]),
      .fall  (pin_fall[p])
    );
  end

  logic store_start, store_done, recall_done, recall_auto;
  logic set_we, clr_we, set_rl, wr_ok, cmd_live;

  nvsr_seq #(
    .PUP_CYCLES    (PUP_CYCLES),
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .store_fall  (pin_fall[0]),
    .recall_fall (pin_fall[1]),
    .supply_low  (supply_low),
    .wel         (wen_latch),
    .prl         (recall_latch),
    .busy        (busy),
    .store_start (store_start),
    .store_done  (store_done),
    .recall_done (recall_done),
    .recall_auto (recall_auto)
  );

  always_comb begin
    cmd_live = cmd_valid & ~busy;
    set_we   = cmd_live & (cmd_op == OP_WEN_SET);
    clr_we   = (cmd_live & (cmd_op == OP_WEN_CLR)) | store_done | supply_low;
    set_rl   = recall_done & ~recall_auto;
    wr_ok    = wr_en & ~busy & wen_latch & recall_latch;
  end

  nvsr_latches u_latches (
    .clk    (clk),
    .rst_n  (rst_int),
    .set_we (set_we),
    .clr_we (clr_we),
    .set_rl (set_rl),
    .wel    (wen_latch),
    .prl    (recall_latch)
  );

  nvsr_arrays #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arrays (
    .clk         (clk),
    .rst_n       (rst_int),
    .wr_ok       (wr_ok),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .copy_to_nv  (store_done),
    .copy_to_ram (recall_done),
    .rd_addr     (rd_addr),
    .ram_rdata   (ram_rdata),
    .nv_rdata    (nv_rdata)
  );
endmodule

module nvsr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       supply_low,
  input logic       busy,
  input logic       wel,
  input logic       prl,
  input logic       store_start,
  input logic       store_done,
  input logic       recall_done,
  input logic       recall_auto
);
  // R2
  low_supply_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !wel);
  // R2
  wel_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cmd_valid && cmd_op == 2'b00 && !busy && !supply_low));
  // R3
  store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> (wel && prl && !supply_low && !busy));
  // R4
  store_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !wel);
  // R5
  recall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_done && !recall_auto) |=> prl);
  // R5
  prl_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prl) |-> $past(recall_done));
endmodule

bind nvsr_ctrl nvsr_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .supply_low  (supply_low),
  .busy        (busy),
  .wel         (wen_latch),
  .prl         (recall_latch),
  .store_start (store_start),
  .store_done  (store_done),
  .recall_done (recall_done),
  .recall_auto (recall_auto)
);

// File: tb/nvsr_ctrl_tb.sv
module nvsr_ctrl_tb;
  localparam int WORDS = 16;
  localparam int WIDTH = 16;
  localparam int AW    = 4;
  localparam int PUP   = 20;
  localparam int STO   = 64;
  localparam int RCL   = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid, store_pin_n, recall_pin_n, supply_low, wr_en;
  logic [1:0]       cmd_op;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [WIDTH-1:0] wr_data, ram_rdata, nv_rdata;
  logic             busy, wen_latch, recall_latch;

  always #5 clk = ~clk;

  nvsr_ctrl #(
    .WORDS(WORDS), .WIDTH(WIDTH), .PUP_CYCLES(PUP),
    .STORE_CYCLES(STO), .RECALL_CYCLES(RCL), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .store_pin_n(store_pin_n), .recall_pin_n(recall_pin_n),
    .supply_low(supply_low), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .ram_rdata(ram_rdata),
    .nv_rdata(nv_rdata), .busy(busy), .wen_latch(wen_latch),
    .recall_latch(recall_latch)
  );

  int compared = 0;
  int mismatched = 0;

  logic [WIDTH-1:0] ram_m [WORDS];
  logic [WIDTH-1:0] nv_m  [WORDS];
  logic             wel_m, prl_m;

  function automatic logic [WIDTH-1:0] seed_exp(int i);
    logic [31:0] v;
    v = (i * 32'h9E37) ^ 32'h5AC3;
    return v[WIDTH-1:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " wen_latch"}, 32'(wen_latch), 32'(wel_m));
    chk({req, " recall_latch"}, 32'(recall_latch), 32'(prl_m));
    chk({req, " busy"}, 32'(busy), 32'd0);
  endtask

  task automatic chk_arrays(string req);
    for (int a = 0; a < WORDS; a++) begin
      rd_addr = AW'(a);
      #1;
      chk({req, " ram"}, 32'(ram_rdata), 32'(ram_m[a]));
      chk({req, " nv"}, 32'(nv_rdata), 32'(nv_m[a]));
    end
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
  endtask

  // issue a command, return number of cycles busy was high afterwards
  task automatic send_cmd(logic [1:0] op, output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic write_word(int a, logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // pulse store (sel=0) or recall (sel=1) pin or both (sel=2) for 3 cycles
  task automatic pin_pulse(int sel);
    @(negedge clk);
    if (sel != 1) store_pin_n = 1'b0;
    if (sel != 0) recall_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    store_pin_n = 1'b1; recall_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    wait_idle();
  endtask

  task automatic m_store();
    if (wel_m && prl_m) begin
      for (int a = 0; a < WORDS; a++) nv_m[a] = ram_m[a];
      wel_m = 1'b0;
    end
  endtask

  task automatic m_recall();
    for (int a = 0; a < WORDS; a++) ram_m[a] = nv_m[a];
    prl_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n, rises, lo, hi;
    logic pb;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    store_pin_n = 1'b1; recall_pin_n = 1'b1; supply_low = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int a = 0; a < WORDS; a++) begin nv_m[a] = seed_exp(a); ram_m[a] = nv_m[a]; end
    wel_m = 1'b0; prl_m = 1'b0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy), 32'd1);
    chk("R1 reset wen", 32'(wen_latch), 32'd0);
    chk("R1 reset recall", 32'(recall_latch), 32'd0);
    rst_n = 1'b1;
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    lo = PUP + RCL; hi = PUP + RCL + 3;
    chk("R1 power-up busy length in window", 32'(n >= lo && n <= hi), 32'd1);
    chk_state("R1 after power-on recall");
    chk_arrays("R1 power-on recall");

    // R10 write refused with latches clear
    write_word(3, 16'hBEEF);
    chk_arrays("R10 write without latches");

    // R2 set enable, R3 store refused without recall-done
    send_cmd(2'b00, n); wel_m = 1'b1;
    chk_state("R2 set enable");
    send_cmd(2'b10, n);
    chk("R3 store without recall busy", 32'(n), 32'd0);
    chk_state("R3 store without recall");
    chk_arrays("R3 store without recall");

    // R5 software recall
    send_cmd(2'b11, n); m_recall();
    chk("R5 recall length", 32'(n), 32'(RCL));
    chk_state("R5 recall");

    // R10 writes accepted
    for (int a = 0; a < 4; a++) begin
      logic [WIDTH-1:0] d;
      d = WIDTH'($urandom);
      write_word(a * 5 % WORDS, d); ram_m[a * 5 % WORDS] = d;
    end
    chk_arrays("R10 writes accepted");

    // R2 supply_low clears and beats set
    @(negedge clk); supply_low = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b00;
    @(negedge clk); supply_low = 1'b0; cmd_valid = 1'b0; wel_m = 1'b0;
    chk_state("R2 supply low over set");
    send_cmd(2'b10, n);
    chk("R3 store without enable busy", 32'(n), 32'd0);
    chk_arrays("R3 store without enable");

    // R3 store refused while supply_low high
    send_cmd(2'b00, n); wel_m = 1'b1;
    @(negedge clk); supply_low = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk); supply_low = 1'b0; cmd_valid = 1'b0; wel_m = 1'b0;
    chk("R3 store under supply low busy", 32'(busy), 32'd0);
    chk_arrays("R3 store under supply low");

    // R4 software store
    send_cmd(2'b00, n); wel_m = 1'b1;
    send_cmd(2'b10, n); m_store();
    chk("R4 store length", 32'(n), 32'(STO));
    chk_state("R4 store");
    chk_arrays("R4 store");

    // R7 clear ignored during recall
    send_cmd(2'b00, n); wel_m = 1'b1;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk); cmd_op = 2'b01;
    @(negedge clk); cmd_valid = 1'b0;
    wait_idle(); m_recall();
    chk_state("R7 clear during recall ignored");
    // R7 write ignored during store
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk); cmd_valid = 1'b0; wr_en = 1'b1; wr_addr = 4'd7; wr_data = 16'h1234;
    @(negedge clk); wr_en = 1'b0;
    wait_idle(); m_store();
    chk_state("R7 write during store");
    chk_arrays("R7 write during store ignored");

    // R8 abort store on supply low
    send_cmd(2'b00, n); wel_m = 1'b1;
    write_word(9, 16'hA5A5); ram_m[9] = 16'hA5A5;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b10;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0; wel_m = 1'b0;
    chk("R8 busy drops after abort", 32'(busy), 32'd0);
    chk_state("R8 abort");
    chk_arrays("R8 abort keeps shadow");

    // R6 both pins: store wins when allowed
    send_cmd(2'b00, n); wel_m = 1'b1;
    write_word(2, 16'h0F0F); ram_m[2] = 16'h0F0F;
    pin_pulse(2); m_store();
    chk_state("R6 both pins store");
    chk_arrays("R6 both pins store");
    // R6 both pins: recall when store refused
    send_cmd(2'b00, n); wel_m = 1'b1;
    write_word(2, 16'h7777); ram_m[2] = 16'h7777;
    send_cmd(2'b01, n); wel_m = 1'b0;
    pin_pulse(2); m_recall();
    chk_state("R6 both pins recall");
    chk_arrays("R6 both pins recall");

    // R9 held pins start one operation
    send_cmd(2'b00, n); wel_m = 1'b1;
    rises = 0; pb = 1'b0;
    @(negedge clk); store_pin_n = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy && !pb) rises++;
      pb = busy;
    end
    store_pin_n = 1'b1; m_store();
    chk("R9 held store pin one op", 32'(rises), 32'd1);
    chk_state("R9 held store");
    rises = 0; pb = 1'b0;
    @(negedge clk); recall_pin_n = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (busy && !pb) rises++;
      pb = busy;
    end
    recall_pin_n = 1'b1; m_recall();
    chk("R9 held recall pin one op", 32'(rises), 32'd1);
    chk_arrays("R9 held pins");

    // random mix against the model
    for (int it = 0; it < 60; it++) begin
      int act;
      act = int'($urandom % 8);
      case (act)
        0: begin send_cmd(2'b00, n); wel_m = 1'b1; end
        1: begin send_cmd(2'b01, n); wel_m = 1'b0; end
        2: begin send_cmd(2'b10, n); m_store(); end
        3: begin send_cmd(2'b11, n); m_recall(); end
        4: begin pin_pulse(0); m_store(); end
        5: begin pin_pulse(1); m_recall(); end
        6: begin
          int a;
          logic [WIDTH-1:0] d;
          a = int'($urandom % WORDS); d = WIDTH'($urandom);
          write_word(a, d);
          if (wel_m && prl_m) ram_m[a] = d;
        end
        default: begin
          @(negedge clk); supply_low = 1'b1;
          @(negedge clk); supply_low = 1'b0; wel_m = 1'b0;
        end
      endcase
      chk_state("R3 R5 R10 random mix");
      chk_arrays("R4 R5 R10 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule